// File: doc/BRIEF.md
# Watchdog Timer with Guarded Shutdown

This block watches for signs of life from software. It counts tick pulses that come from a separate free-running oscillator. The ticks arrive already synchronized to the register clock, one cycle high per tick. Each kick from software returns the count to zero. If the count reaches the selected timeout while the watchdog is armed, the block raises a one-cycle system reset request and then starts counting again from zero.

Software controls the block through an 8-bit control register. The register holds an arm bit, a shutdown-unlock bit and a 3-bit timeout select. Arming the watchdog needs no special step. Disarming it needs a timed two-step sequence, so a runaway program cannot switch it off by accident. The first write sets both the unlock bit and the arm bit. A write with the arm bit low must then follow within four register-clock cycles. The unlock bit clears itself when that window ends.

Top module: `wdog_guard`

## Requirements
- R1: After reset, rd_data reads 0x00 and sys_rst_o is low.
- R2: rd_data shows the timeout select in bits 2..0, the arm bit in bit 3 and the unlock bit in bit 4. Bits 7..5 always read zero. A write loads the timeout select from wr_data[2:0].
- R3: Any write with wr_data[3]=1 sets the arm bit, whatever the state of the unlock bit.
- R4: A write with wr_data[3]=0 while the unlock bit is 0 leaves the arm bit at its current value.
- R5: A write with wr_data[3]=0 clears the arm bit if it happens on any of the four cycles after a write with wr_data[4]=1. The fourth cycle is included.
- R6: A write with wr_data[4]=1 sets the unlock bit and restarts its window. The unlock bit reads 1 for exactly four cycles after that write and then returns to 0 by itself. Writing 0 to bit 4 never clears it. A clearing write on the fifth cycle leaves the arm bit set.
- R7: With select value s, the timeout is 2^(BASE_SHIFT+s) ticks. At the default setting this gives 16K ticks for s=0 up to 2048K ticks for s=7. sys_rst_o goes high for exactly one cycle, in the cycle after the edge that samples the timeout-th tick.
- R8: A kick clears the count to zero. The next timeout then needs the full number of ticks, counted after the kick.
- R9: The count advances only on cycles where tick is high.
- R10: While the arm bit is 0, the count stays at zero and sys_rst_o stays low. So arming always starts the count from zero.
- R11: After a timeout the count restarts at zero. With no kick, the next pulse follows one full timeout later.
- R12: If the timeout select is lowered below the current count, the next tick raises the reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle oscillator tick, already synchronized |
| kick | input | 1 | Clears the watchdog count |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register contents |
| sys_rst_o | output | 1 | One-cycle system reset request on timeout |

## Verification
The assertions assume that tick, kick and wr_en are synchronous single-cycle levels sampled on clk. They also assume BASE_SHIFT is at least 1, so two timeouts can never fall on back-to-back cycles. The bench sets BASE_SHIFT to 4, so every select value times out within a few thousand cycles. It drives all inputs between clock edges. The random phase draws ticks, sparse kicks and occasional writes with any byte value, so unlock windows, shutdown attempts and select changes mix freely while the unlock bit stays purely in hardware's hands.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam int REG_W   = 8;
  localparam int PS_W    = 3;
  localparam int PS_LSB  = 0;
  localparam int EN_BIT  = 3;
  localparam int TOE_BIT = 4;

  typedef struct packed {
    logic            unlock;
    logic            arm;
    logic [PS_W-1:0] sel;
  } wdog_ctrl_t;
endpackage

// File: rtl/wdog_ctrl_reg.sv
`timescale 1ns/1ps
module wdog_ctrl_reg
  import wdog_pkg::*;
#(
  parameter int WIN_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output wdog_ctrl_t       ctrl_o
);
  localparam int AW = $clog2(WIN_CYC + 1);

  logic            unlock_q;
  logic            arm_q;
  logic [PS_W-1:0] sel_q;
  logic [AW-1:0]   age_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      unlock_q <= 1'b0;
      arm_q    <= 1'b0;
      sel_q    <= '0;
      age_q    <= '0;
    end else begin
      if (wr_en) begin
        sel_q <= wr_data[PS_LSB +: PS_W];
        if (wr_data[EN_BIT])
          arm_q <= 1'b1;
        else if (unlock_q)
          arm_q <= 1'b0;
      end
      if (wr_en && wr_data[TOE_BIT]) begin
        unlock_q <= 1'b1;
        age_q    <= '0;
      end else if (unlock_q) begin
        if (age_q == AW'(WIN_CYC - 1))
          unlock_q <= 1'b0;
        age_q <= age_q + 1'b1;
      end
    end
  end

  assign ctrl_o.unlock = unlock_q;
  assign ctrl_o.arm    = arm_q;
  assign ctrl_o.sel    = sel_q;
endmodule

// File: rtl/wdog_tick_counter.sv
`timescale 1ns/1ps
module wdog_tick_counter #(
  parameter int BASE_SHIFT = 14,
  parameter int SEL_W      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic [SEL_W-1:0] sel,
  input  logic             tick,
  input  logic             kick,
  output logic             expire_o
);
  localparam int NSEL = 1 << SEL_W;
  localparam int CW   = BASE_SHIFT + NSEL;

  logic [CW-1:0] lim_m1 [NSEL];
  logic [CW-1:0] cnt_q;
  logic          hit;

  for (genvar g = 0; g < NSEL; g++) begin : g_lim
    assign lim_m1[g] = (CW'(1) << (BASE_SHIFT + g)) - CW'(1);
  end

  assign hit = (cnt_q >= lim_m1[sel]);

  always_ff @(posedge clk) begin
    if (rst || !arm || kick) begin
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else if (tick) begin
      if (hit) begin
        cnt_q    <= '0;
        expire_o <= 1'b1;
      end else begin
        cnt_q    <= cnt_q + 1'b1;
        expire_o <= 1'b0;
      end
    end else begin
      expire_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_guard.sv
`timescale 1ns/1ps
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int BASE_SHIFT = 14,
  parameter int WIN_CYC    = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       kick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       sys_rst_o
);
  wdog_ctrl_t ctrl;

  wdog_ctrl_reg #(.WIN_CYC(WIN_CYC)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctrl_o  (ctrl)
  );

  wdog_tick_counter #(.BASE_SHIFT(BASE_SHIFT), .SEL_W(PS_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .arm      (ctrl.arm),
    .sel      (ctrl.sel),
    .tick     (tick),
    .kick     (kick),
    .expire_o (sys_rst_o)
  );

  always_comb begin
    rd_data                     = '0;
    rd_data[PS_LSB +: PS_W]     = ctrl.sel;
    rd_data[EN_BIT]             = ctrl.arm;
    rd_data[TOE_BIT]            = ctrl.unlock;
  end
endmodule

// File: rtl/wdog_guard_chk.sv
`timescale 1ns/1ps
module wdog_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       kick,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       sys_rst_o
);
  logic [2:0] open_q;

  always_ff @(posedge clk) begin
    if (rst)
      open_q <= '0;
    else if (wr_en && wr_data[4])
      open_q <= '0;
    else if (rd_data[4] && open_q != 3'd7)
      open_q <= open_q + 1'b1;
    else if (!rd_data[4])
      open_q <= '0;
  end

  p_pad_zero_r2: assert property (@(posedge clk) disable iff (rst)
    rd_data[7:5] == 3'b000);

  p_arm_set_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[3]) |=> rd_data[3]);

  p_arm_kept_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[3] && !rd_data[4] && rd_data[3]) |=> rd_data[3]);

  p_window_len_r6: assert property (@(posedge clk) disable iff (rst)
    rd_data[4] |-> (open_q <= 3'd3));

  p_unlock_src_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_data[4]) |-> $past(wr_en && wr_data[4]));

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o |=> !sys_rst_o);

  p_kick_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    kick |=> !sys_rst_o);

  p_tick_cause_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_o) |-> $past(tick));

  p_disarmed_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_data[3] |=> !sys_rst_o);
endmodule

bind wdog_guard wdog_guard_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .kick      (kick),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .sys_rst_o (sys_rst_o)
);

// File: tb/wdog_guard_tb_top.sv
`timescale 1ns/1ps
module wdog_guard_tb_top;
  localparam int B = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       kick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       sys_rst_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdog_guard #(.BASE_SHIFT(B), .WIN_CYC(4)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .kick(kick),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .sys_rst_o(sys_rst_o)
  );

  // Reference behaviour built from the requirements
  logic [2:0] m_sel;
  logic       m_arm, m_unl, m_pulse;
  int         m_age, m_cnt;

  function automatic int limit_of(input logic [2:0] s);
    return 1 << (B + int'(s));
  endfunction

  function automatic logic [7:0] model_rd();
    return {3'b000, m_unl, m_arm, m_sel};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sel <= '0; m_arm <= 1'b0; m_unl <= 1'b0; m_age <= 0;
      m_cnt <= 0;  m_pulse <= 1'b0;
    end else begin
      if (wr_en) begin
        m_sel <= wr_data[2:0];
        if (wr_data[3]) m_arm <= 1'b1;
        else if (m_unl) m_arm <= 1'b0;
      end
      if (wr_en && wr_data[4]) begin
        m_unl <= 1'b1; m_age <= 0;
      end else if (m_unl) begin
        if (m_age == 3) m_unl <= 1'b0;
        m_age <= m_age + 1;
      end
      if (!m_arm || kick) begin
        m_cnt <= 0; m_pulse <= 1'b0;
      end else if (tick) begin
        if (m_cnt >= limit_of(m_sel) - 1) begin
          m_cnt <= 0; m_pulse <= 1'b1;
        end else begin
          m_cnt <= m_cnt + 1; m_pulse <= 1'b0;
        end
      end else begin
        m_pulse <= 1'b0;
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [7:0] d, input logic t, input logic k);
    wr_en = w; wr_data = d; tick = t; kick = k;
    @(posedge clk);
    #1;
    chk("model R2", rd_data, model_rd());
    chk("model R7", {7'd0, sys_rst_o}, {7'd0, m_pulse});
  endtask

  task automatic idle(input logic t);
    step(1'b0, 8'h00, t, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk("R1 reg", rd_data, 8'h00);
    chk("R1 pulse", {7'd0, sys_rst_o}, 8'h00);

    step(1'b1, 8'hEB, 1'b0, 1'b0);
    chk("R2 R3 padding and arm", rd_data, 8'h0B);
    step(1'b1, 8'h02, 1'b0, 1'b0);
    chk("R4 locked clear", rd_data, 8'h0A);

    step(1'b1, 8'h1A, 1'b0, 1'b0);
    chk("R6 unlock set", rd_data, 8'h1A);
    idle(1'b0);
    step(1'b1, 8'h02, 1'b0, 1'b0);
    chk("R5 disarm", rd_data, 8'h12);
    idle(1'b0);
    chk("R6 still open", rd_data, 8'h12);
    idle(1'b0);
    chk("R6 self clear", rd_data, 8'h02);

    step(1'b1, 8'h1A, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      idle(1'b0);
      chk("R6 window", rd_data, 8'h1A);
    end
    step(1'b1, 8'h02, 1'b0, 1'b0);
    chk("R5 fourth cycle", rd_data, 8'h02);

    step(1'b1, 8'h1A, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) idle(1'b0);
    chk("R6 closed", rd_data, 8'h0A);
    step(1'b1, 8'h02, 1'b0, 1'b0);
    chk("R6 late clear", rd_data, 8'h0A);

    step(1'b1, 8'h1A, 1'b0, 1'b0);
    step(1'b1, 8'h0A, 1'b0, 1'b0);
    chk("R6 zero write ignored", rd_data, 8'h1A);
    for (int i = 0; i < 3; i++) idle(1'b0);
    chk("R6 after window", rd_data, 8'h0A);

    step(1'b1, 8'h08, 1'b0, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b1);
    for (int i = 1; i <= 16; i++) begin
      idle(1'b1);
      chk("R7 timeout", {7'd0, sys_rst_o}, (i == 16) ? 8'h01 : 8'h00);
    end
    for (int i = 1; i <= 16; i++) begin
      idle(1'b1);
      chk("R11 restart", {7'd0, sys_rst_o}, (i == 16) ? 8'h01 : 8'h00);
    end

    for (int i = 0; i < 10; i++) idle(1'b1);
    step(1'b0, 8'h00, 1'b1, 1'b1);
    chk("R8 kick", {7'd0, sys_rst_o}, 8'h00);
    for (int i = 1; i <= 16; i++) begin
      idle(1'b1);
      chk("R8 full period", {7'd0, sys_rst_o}, (i == 16) ? 8'h01 : 8'h00);
    end

    for (int i = 0; i < 32; i++) begin
      idle(logic'(i % 2));
      chk("R9 gated ticks", {7'd0, sys_rst_o}, (i == 31) ? 8'h01 : 8'h00);
    end

    step(1'b1, 8'h18, 1'b0, 1'b0);
    step(1'b1, 8'h00, 1'b0, 1'b0);
    chk("R10 disarmed", rd_data, 8'h10);
    for (int i = 0; i < 100; i++) begin
      idle(1'b1);
      if (sys_rst_o) chk("R10 quiet", 8'h01, 8'h00);
    end
    chk("R10 no pulse", {7'd0, sys_rst_o}, 8'h00);

    step(1'b1, 8'h0B, 1'b0, 1'b0);
    for (int i = 0; i < 50; i++) idle(1'b1);
    chk("R12 no early pulse", {7'd0, sys_rst_o}, 8'h00);
    step(1'b1, 8'h08, 1'b1, 1'b0);
    chk("R12 write edge", {7'd0, sys_rst_o}, 8'h00);
    idle(1'b1);
    chk("R12 lowered select", {7'd0, sys_rst_o}, 8'h01);

    for (int i = 0; i < 6000; i++) begin
      logic w;
      logic [7:0] d;
      w = ($urandom % 12) == 0;
      d = 8'($urandom);
      if (($urandom % 3) != 0) d[2:1] = 2'b00;
      step(w, d, ($urandom % 4) != 0, ($urandom % 80) == 0);
    end

    finish_run();
  end
endmodule